// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo PCM audio as a slave. A source outside the chip supplies the bit clock, a frame clock that marks left and right words, and a serial data line. The block runs entirely in the bit-clock domain and rebuilds each channel word from the bit stream. It emits the words as a 24-bit left sample and a 24-bit right sample. A one-cycle strobe marks each completed stereo pair.

Three framings are selectable: right-justified, I2S and DSP mode A. A single counter-based framer serves all three. The formats differ in two ways: where the first bit of a word sits relative to a frame-clock edge, and which level of the frame clock marks the left word. The word length is 16, 20 or 24 bits. Samples are aligned to the top of the 24-bit outputs, and the unused low bits are zero.

The output is a stream with a valid strobe and no ready. A serial audio source cannot be paused, so back-pressure is not possible. A consumer must take each pair in the cycle the strobe is high. The sample outputs then hold their value until the next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high at a rising `bit_clk` edge, both sample outputs are cleared to zero, `pair_valid` is low, and any pending left word is discarded.
- R2: `ser_data` and `frame_clk` are sampled on the rising edge of `bit_clk`, and every word arrives most significant bit first.
- R3: With `fmt_sel` = 0 (right-justified), a word consists of the N bits sampled on the N rising edges just before the frame clock toggles. A high frame clock marks the left word and a low frame clock marks the right word. Earlier bits in a longer slot are discarded.
- R4: With `fmt_sel` = 1 or 3 (I2S), each word's first bit is sampled on the second rising edge after any frame-clock transition. A low frame clock marks left and a high frame clock marks right. Bits after the Nth bit of a slot are ignored.
- R5: With `fmt_sel` = 2 (DSP mode A), the left word's first bit is sampled on the second rising edge after a frame-clock rising edge. The right word starts on the very next edge after the left word's last bit. A falling frame-clock edge has no effect, whatever its position.
- R6: `wlen_sel` selects N: 0 gives 16, 1 gives 20, and 2 or 3 give 24. Each sample sits in bits 23 down to 24-N, and the lower 24-N bits are zero.
- R7: `pair_valid` is high for exactly one cycle for each completed stereo pair, and both sample outputs change in that same cycle. When `pair_valid` is low, the outputs keep their previous values.
- R8: `pair_valid` is high in the cycle that follows the rising edge that samples the right word's last bit (I2S, DSP mode A). In right-justified mode it is high in the cycle that follows the rising edge that first sees the frame clock go high.
- R9: No pair is emitted for a right word unless a complete left word has been captured since the last pair or reset. In I2S, a word cut short by a frame-clock transition before N bits is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; the only clock of the block |
| rst | input | 1 | Synchronous reset, active high |
| frame_clk | input | 1 | Left/right frame clock from the source |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 or 3 I2S, 2 DSP mode A |
| wlen_sel | input | 2 | Word length: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| left_sample | output | 24 | Last left sample, top-aligned |
| right_sample | output | 24 | Last right sample, top-aligned |
| pair_valid | output | 1 | One-cycle strobe: a new stereo pair is on the outputs |

## Verification
Each framing is driven with slots that are exactly as long as the word and with slots that are longer. Padding bits are set to one, so any bit taken from outside the word window shows up in the result. The minimum and maximum slot lengths separate a correct MSB position from a position that is off by one bit. Each word length is used with sample values whose low bits are non-zero, so that faults in alignment and zero-fill cannot hide. Directed patterns cover several cases: a right word with no left before it, an I2S left word cut short, two pairs sent back to back, and a DSP frame pulse wide enough to overlap the left word. The cycle of each strobe is also compared against the expected cycle.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;

  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_RJ      = 2'd0,
    FMT_I2S     = 2'd1,
    FMT_DSPA    = 2'd2,
    FMT_I2S_ALT = 2'd3
  } fmt_e;

  // Number of bits per word for a word-length code.
  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = CNT_W'(16);
      2'd1:    n = CNT_W'(20);
      default: n = CNT_W'(SAMPLE_W);
    endcase
    return n;
  endfunction

  // Move the N received bits (held at the bottom) to the top; zero the rest.
  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [1:0]          sel);
    logic [SAMPLE_W-1:0] res;
    res = raw << (SAMPLE_W - int'(word_bits(sel)));
    return res;
  endfunction

endpackage

// File: rtl/sarx_edge_det.sv
`timescale 1ns/1ps
module sarx_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lrc,
  output logic edge_any,
  output logic edge_rise
);

  logic lrc_q;

  always_ff @(posedge clk) begin
    if (rst) lrc_q <= 1'b0;
    else     lrc_q <= lrc;
  end

  assign edge_any  = lrc ^ lrc_q;
  assign edge_rise = lrc & ~lrc_q;

endmodule

// File: rtl/sarx_word_framer.sv
`timescale 1ns/1ps
module sarx_word_framer
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic                sdata,
  input  logic                lrc,
  input  logic                edge_any,
  input  logic                edge_rise,
  output logic                cap_stb,
  output logic                cap_right,
  output logic [SAMPLE_W-1:0] cap_raw
);

  logic [SAMPLE_W-1:0] sreg;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    nb;
  logic                active;
  logic                chan;
  logic                is_rj;
  logic                is_dsp;
  logic                start;
  logic                last_bit;

  assign nb       = word_bits(wlen);
  assign is_rj    = (fmt_e'(fmt) == FMT_RJ);
  assign is_dsp   = (fmt_e'(fmt) == FMT_DSPA);
  assign start    = is_dsp ? edge_rise : edge_any;
  assign last_bit = active && (cnt == nb - CNT_W'(1));

  // History of the most recent bits, newest at bit 0.
  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else     sreg <= {sreg[SAMPLE_W-2:0], sdata};
  end

  always_comb begin
    if (is_rj) begin
      cap_stb   = edge_any;
      cap_right = lrc;               // rising to high ends the right word
      cap_raw   = sreg;              // LSB was taken on the previous edge
    end else begin
      cap_stb   = last_bit && !start;
      cap_right = chan;
      cap_raw   = {sreg[SAMPLE_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      chan   <= 1'b0;
    end else if (is_rj) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      chan   <= is_dsp ? 1'b0 : lrc;
    end else if (active) begin
      if (last_bit) begin
        cnt <= '0;
        if (is_dsp && !chan) chan   <= 1'b1;
        else                 active <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R4: the bit counter never runs past the word length.
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < nb));

  // R5: in DSP mode A the right word starts right after the left word ends.
  a_r5_right_follows_left: assert property (@(posedge clk) disable iff (rst)
    (is_dsp && cap_stb && !cap_right && !edge_rise) |=> (active && chan && cnt == '0));

endmodule

// File: rtl/sarx_pair_asm.sv
`timescale 1ns/1ps
module sarx_pair_asm
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_stb,
  input  logic                cap_right,
  input  logic [SAMPLE_W-1:0] cap_raw,
  input  logic [1:0]          wlen,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                pair_valid
);

  logic [SAMPLE_W-1:0] left_hold;
  logic [SAMPLE_W-1:0] aligned;
  logic                left_ok;

  assign aligned = msb_align(cap_raw, wlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold    <= '0;
      left_ok      <= 1'b0;
      left_sample  <= '0;
      right_sample <= '0;
      pair_valid   <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (cap_stb) begin
        if (!cap_right) begin
          left_hold <= aligned;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_sample  <= left_hold;
          right_sample <= aligned;
          pair_valid   <= 1'b1;
          left_ok      <= 1'b0;
        end
      end
    end
  end

  // R1: reset leaves the outputs cleared.
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pair_valid && left_sample == '0 && right_sample == '0));

  // R7: the strobe never lasts two cycles.
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R7: the outputs move only together with the strobe.
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_sample) && $stable(right_sample)));

  // R6: with 16-bit words the low byte of a fresh pair is zero.
  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && wlen == 2'd0) |-> (left_sample[7:0] == 8'd0 && right_sample[7:0] == 8'd0));

endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import sarx_pkg::*;
(
  input  logic                bit_clk,
  input  logic                rst,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                pair_valid
);

  logic                edge_any;
  logic                edge_rise;
  logic                cap_stb;
  logic                cap_right;
  logic [SAMPLE_W-1:0] cap_raw;

  sarx_edge_det u_edge (
    .clk       (bit_clk),
    .rst       (rst),
    .lrc       (frame_clk),
    .edge_any  (edge_any),
    .edge_rise (edge_rise)
  );

  sarx_word_framer u_framer (
    .clk       (bit_clk),
    .rst       (rst),
    .fmt       (fmt_sel),
    .wlen      (wlen_sel),
    .sdata     (ser_data),
    .lrc       (frame_clk),
    .edge_any  (edge_any),
    .edge_rise (edge_rise),
    .cap_stb   (cap_stb),
    .cap_right (cap_right),
    .cap_raw   (cap_raw)
  );

  sarx_pair_asm u_asm (
    .clk          (bit_clk),
    .rst          (rst),
    .cap_stb      (cap_stb),
    .cap_right    (cap_right),
    .cap_raw      (cap_raw),
    .wlen         (wlen_sel),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .pair_valid   (pair_valid)
  );

endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic [7:0]  slot;   // slot bits (RJ/I2S) or trailing pad bits (DSP)
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd2, 8'd32, 24'hA5C3F1, 24'h5A3C0E},
    '{2'd0, 2'd0, 8'd24, 24'h800155, 24'h7FFEAA},
    '{2'd0, 2'd1, 8'd20, 24'hF0F0F7, 24'h0F0F0B},
    '{2'd1, 2'd2, 8'd32, 24'h123457, 24'hFEDCB9},
    '{2'd1, 2'd0, 8'd17, 24'hC0DE33, 24'h3A5B77},
    '{2'd3, 2'd3, 8'd25, 24'h800001, 24'h7FFFFE},
    '{2'd2, 2'd2, 8'd4,  24'h9ABCDF, 24'h2468AC},
    '{2'd2, 2'd1, 8'd0,  24'hE1E1E5, 24'h1E1E1D},
    '{2'd2, 2'd0, 8'd6,  24'h55AA77, 24'hAA5533}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  wlen_sel = 2'd0;
  logic [23:0] left_sample;
  logic [23:0] right_sample;
  logic        pair_valid;

  int applied = 0;
  int fails   = 0;
  int vseen   = 0;
  int vidx    = -1;
  int bitno   = 0;
  int lsb_idx = 0;
  int trl_idx = 0;
  int cyc     = 0;
  bit done    = 1'b0;
  logic [23:0] got_l;
  logic [23:0] got_r;

  always #10 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .bit_clk      (clk),
    .rst          (rst),
    .frame_clk    (frame_clk),
    .ser_data     (ser_data),
    .fmt_sel      (fmt_sel),
    .wlen_sel     (wlen_sel),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .pair_valid   (pair_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] wl);
    return (wl == 2'd0) ? 16 : (wl == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w, input logic [1:0] wl);
    logic [23:0] m;
    m = (wl == 2'd0) ? 24'hFFFF00 : (wl == 2'd1) ? 24'hFFFFF0 : 24'hFFFFFF;
    return w & m;
  endfunction

  // Drive one bit at a falling edge; note any strobe seen there first.
  task automatic bit_out(input logic l, input logic d);
    @(negedge clk);
    if (pair_valid) begin
      vseen++;
      vidx  = bitno;
      got_l = left_sample;
      got_r = right_sample;
    end
    frame_clk = l;
    ser_data  = d;
    bitno++;
  endtask

  task automatic send_word(input logic l, input logic [23:0] w, input int n);
    for (int j = 0; j < n; j++) bit_out(l, w[23-j]);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
    @(negedge clk);
    rst = 1'b1; frame_clk = 1'b0; ser_data = 1'b0;
    fmt_sel = f; wlen_sel = wl;
    repeat (2) @(negedge clk);
    chk("R1 reset state", {7'd0, pair_valid, left_sample | right_sample}, 32'd0);
    rst = 1'b0;
    vseen = 0; vidx = -1; bitno = 0;
  endtask

  task automatic lead(input logic [1:0] f);
    for (int k = 0; k < 2; k++) bit_out((f == 2'd2) ? 1'b0 : 1'b1, 1'b1);
  endtask

  task automatic trail(input logic [1:0] f);
    trl_idx = bitno;
    for (int k = 0; k < 3; k++) bit_out((f == 2'd0) ? 1'b1 : 1'b0, 1'b1);
  endtask

  // One stereo frame; padding bits are ones so stray bits would show.
  task automatic body(input logic [1:0] f, input int n, input int slot,
                      input logic [23:0] l, input logic [23:0] r);
    if (f == 2'd0) begin
      for (int k = 0; k < slot - n; k++) bit_out(1'b1, 1'b1);
      send_word(1'b1, l, n);
      for (int k = 0; k < slot - n; k++) bit_out(1'b0, 1'b1);
      send_word(1'b0, r, n);
      lsb_idx = bitno - 1;
    end else if (f == 2'd2) begin
      bit_out(1'b1, 1'b1);
      send_word(1'b0, l, n);
      send_word(1'b0, r, n);
      lsb_idx = bitno - 1;
      for (int k = 0; k < slot; k++) bit_out(1'b0, 1'b1);
    end else begin
      bit_out(1'b0, 1'b1);
      send_word(1'b0, l, n);
      for (int k = 0; k < slot - 1 - n; k++) bit_out(1'b0, 1'b1);
      bit_out(1'b1, 1'b1);
      send_word(1'b1, r, n);
      lsb_idx = bitno - 1;
      for (int k = 0; k < slot - 1 - n; k++) bit_out(1'b1, 1'b1);
    end
  endtask

  initial begin
    // Table walk: every framing, word length and slot size.
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int n;
      int exp_idx;
      string ftag;
      v = VECS[i];
      n = nbits(v.wl);
      ftag = (v.fmt == 2'd0) ? "R3" : (v.fmt == 2'd2) ? "R5" : "R4";
      do_reset(v.fmt, v.wl);
      lead(v.fmt);
      body(v.fmt, n, int'(v.slot), v.l, v.r);
      trail(v.fmt);
      exp_idx = (v.fmt == 2'd0) ? trl_idx + 1 : lsb_idx + 1;
      chk("R7 strobe count", vseen, 1);
      chk("R8 strobe cycle", vidx, exp_idx);
      chk($sformatf("R2 %s R6 left", ftag),  {8'd0, got_l}, {8'd0, expect_word(v.l, v.wl)});
      chk($sformatf("R2 %s R6 right", ftag), {8'd0, got_r}, {8'd0, expect_word(v.r, v.wl)});
    end

    // R9: right-justified right word with no left before it.
    do_reset(2'd0, 2'd2);
    send_word(1'b0, 24'h777777, 24);
    trail(2'd0);
    chk("R9 orphan right strobes", vseen, 0);
    chk("R9 orphan right outputs", {8'd0, left_sample | right_sample}, 32'd0);

    // R9: I2S left cut short, then a full right word.
    do_reset(2'd1, 2'd0);
    lead(2'd1);
    bit_out(1'b0, 1'b1);
    send_word(1'b0, 24'hABCDEF, 10);
    bit_out(1'b1, 1'b1);
    send_word(1'b1, 24'h123456, 16);
    trail(2'd1);
    chk("R9 short left strobes", vseen, 0);
    chk("R9 short left outputs", {8'd0, left_sample | right_sample}, 32'd0);

    // R7: two I2S pairs back to back; last pair wins.
    do_reset(2'd1, 2'd1);
    lead(2'd1);
    body(2'd1, 20, 22, 24'h111111, 24'h222222);
    body(2'd1, 20, 22, 24'hCAFE5A, 24'h0BEEF7);
    trail(2'd1);
    chk("R7 back-to-back count", vseen, 2);
    chk("R7 second left", {8'd0, got_l}, {8'd0, 24'hCAFE50});
    chk("R7 second right", {8'd0, got_r}, {8'd0, 24'h0BEEF0});

    // R5: DSP frame pulse that stays high over the first left bits.
    do_reset(2'd2, 2'd0);
    lead(2'd2);
    bit_out(1'b1, 1'b0);
    for (int j = 0; j < 16; j++) bit_out(j < 2, 24'hB00F00 >> (23 - j) & 24'h1 ? 1'b1 : 1'b0);
    send_word(1'b0, 24'h6C3900, 16);
    trail(2'd2);
    chk("R5 wide pulse count", vseen, 1);
    chk("R5 wide pulse left", {8'd0, got_l}, {8'd0, 24'hB00F00});
    chk("R5 wide pulse right", {8'd0, got_r}, {8'd0, 24'h6C3900});

    do_reset(2'd0, 2'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule